// File: doc/BRIEF.md
# Tagged Memory Granule Controller

This block guards a small on-chip data store and keeps one hidden validity bit for every 16-byte granule. The bit marks a granule whose contents were last written whole by a capability store whose source tag was set. Ordinary data writes cannot set it, and they clear it for every granule they touch. Ordinary data reads never see it. As a result, software can never forge a valid capability from plain data.

Requests arrive on a single valid/ready port and come in four kinds: a byte-granular data read, a byte-granular data write, a 128-bit capability read and a 128-bit capability write. A data access covers 1 to 16 bytes at any byte address, so it may straddle two granules. The data array and the tag array are updated in the same clock edge. Each accepted request gets exactly one registered response carrying data, a tag bit and an error flag.

Top module: `tagged_granule_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every granule's tag reads as clear, and no response is signalled until a request is accepted.
- R2: `reqReady` is always high. Request kinds are encoded on `reqKind` as 0 for a data read, 1 for a data write, 2 for a capability read and 3 for a capability write. `rspValid` is high in exactly the cycle after each accepted request and low after an idle cycle.
- R3: A capability write (kind 3) to a 16-byte aligned address with `reqWTag` high stores all 128 bits and sets that granule's tag. A capability read (kind 2) returns the 128 data bits and the granule's tag in the same response. Reads leave tags unchanged.
- R4: A capability write with `reqWTag` low stores its data and clears the granule's tag.
- R5: A capability read or write whose address has any of bits [3:0] set responds with `rspErr` high. It changes no data and no tag. Every error response has zero data and a clear tag.
- R6: A data write (kind 1) clears the tag of every granule containing at least one written byte, including both granules when the write crosses a 16-byte boundary. Other granules keep their tags.
- R7: A data read (kind 0) returns byte `addr+i` in `rspData[8i+7:8i]` for i below the size, with zeros above. Its `rspTag` is always 0.
- R8: A data read or write whose `reqSize` is 0 or greater than 16 responds with `rspErr` high and changes nothing.
- R9: Address bits above the byte range of the store are ignored. A data access running past the last granule continues at granule 0.
- R10: A data write changes only the addressed bytes: byte i of the write takes `reqWData[8i+7:8i]`, and all other bytes of the touched granules keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken (always high) |
| reqKind | input | 2 | 0 data read, 1 data write, 2 capability read, 3 capability write |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 5 | Byte count for data accesses (1 to 16) |
| reqWData | input | 128 | Write data, byte i in bits [8i+7:8i] |
| reqWTag | input | 1 | Source tag for capability writes |
| rspValid | output | 1 | Response present |
| rspErr | output | 1 | Request was rejected |
| rspData | output | 128 | Read data, zero for writes and errors |
| rspTag | output | 1 | Granule tag on capability reads, zero otherwise |

## Verification
Every result of this block appears in the single cycle after the edge that accepts the request. A read reflects any write accepted one cycle earlier. The bench drives each request on a falling edge, lets the next rising edge accept it, and samples the response shortly after that same rising edge. This avoids both the accepting edge and the following one. Tag and data effects of a write are then checked by a capability read issued in the very next cycle. The result of an idle cycle is sampled the same way.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

  localparam int GRAN_BYTES = 16;
  localparam int GRAN_BITS  = GRAN_BYTES * 8;
  localparam int OFF_W      = $clog2(GRAN_BYTES);
  localparam int SIZE_W     = OFF_W + 1;

  typedef enum logic [1:0] {
    KIND_DRD = 2'd0,
    KIND_DWR = 2'd1,
    KIND_CRD = 2'd2,
    KIND_CWR = 2'd3
  } reqKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;     // request accepted this cycle
    logic err;      // reject, respond with error
    logic rdData;   // byte read
    logic rdCap;    // capability read
    logic wrLo;     // write the first granule
    logic wrHi;     // write the following granule
    logic fullRow;  // all 16 bytes, aligned
    logic capWr;    // tag comes from the request
    logic tagVal;   // tag value for a capability write
  } dpCtl_t;

endpackage

// File: rtl/tgc_ctrl.sv
module tgc_ctrl
  import tgc_pkg::*;
(
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqWTag,
  output logic              reqReady,
  output dpCtl_t            ctl
);

  localparam int SUM_W = SIZE_W + 1;

  reqKind_e          kind;
  logic              sizeOk;
  logic              aligned;
  logic              spans;
  logic [SUM_W-1:0]  endByte;

  assign reqReady = 1'b1;

  always_comb begin
    kind    = reqKind_e'(reqKind);
    sizeOk  = (reqSize != '0) && (reqSize <= SIZE_W'(GRAN_BYTES));
    aligned = (reqOff == '0);
    endByte = SUM_W'(reqOff) + SUM_W'(reqSize);
    spans   = endByte > SUM_W'(GRAN_BYTES);

    ctl      = '0;
    ctl.fire = reqValid;
    if (reqValid) begin
      unique case (kind)
        KIND_DRD: begin
          if (sizeOk) ctl.rdData = 1'b1;
          else        ctl.err    = 1'b1;
        end
        KIND_DWR: begin
          if (sizeOk) begin
            ctl.wrLo = 1'b1;
            ctl.wrHi = spans;
          end else begin
            ctl.err = 1'b1;
          end
        end
        KIND_CRD: begin
          if (aligned) ctl.rdCap = 1'b1;
          else         ctl.err   = 1'b1;
        end
        KIND_CWR: begin
          if (aligned) begin
            ctl.wrLo    = 1'b1;
            ctl.fullRow = 1'b1;
            ctl.capWr   = 1'b1;
            ctl.tagVal  = reqWTag;
          end else begin
            ctl.err = 1'b1;
          end
        end
        default: ctl.err = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/tgc_datapath.sv
module tgc_datapath
  import tgc_pkg::*;
#(
  parameter int GRANULES = 16,
  localparam int IDX_W   = $clog2(GRANULES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [IDX_W-1:0]     idxLo,
  input  logic [OFF_W-1:0]     reqOff,
  input  logic [SIZE_W-1:0]    reqSize,
  input  logic [GRAN_BITS-1:0] reqWData,
  output logic                 rspValid,
  output logic                 rspErr,
  output logic [GRAN_BITS-1:0] rspData,
  output logic                 rspTag
);

  localparam int WIN_BYTES = 2 * GRAN_BYTES;
  localparam int WIN_BITS  = 2 * GRAN_BITS;
  localparam int SH_W      = OFF_W + 3;

  logic [GRAN_BITS-1:0] memQ [GRANULES];
  logic [GRANULES-1:0]  tagQ;

  logic [IDX_W-1:0]      idxHi;
  logic [WIN_BITS-1:0]   win;
  logic [GRAN_BYTES-1:0] sizeMask;
  logic [WIN_BYTES-1:0]  wrByteMask;
  logic [WIN_BITS-1:0]   wrBitMask;
  logic [GRAN_BITS-1:0]  rdBitMask;
  logic [WIN_BITS-1:0]   placed;
  logic [WIN_BITS-1:0]   newWin;
  logic [GRAN_BITS-1:0]  rdWin;
  logic [SH_W-1:0]       bitShift;

  assign idxHi    = idxLo + IDX_W'(1);
  assign win      = {memQ[idxHi], memQ[idxLo]};
  assign bitShift = {reqOff, 3'b000};

  // byte enables for the request size
  always_comb begin
    if (ctl.fullRow || reqSize >= SIZE_W'(GRAN_BYTES))
      sizeMask = '1;
    else
      sizeMask = GRAN_BYTES'((17'd1 << reqSize) - 17'd1);
    wrByteMask = {{GRAN_BYTES{1'b0}}, sizeMask} << reqOff;
  end

  // expand byte enables to bit enables
  genvar b;
  generate
    for (b = 0; b < WIN_BYTES; b++) begin : g_wrMask
      assign wrBitMask[8*b +: 8] = {8{wrByteMask[b]}};
    end
    for (b = 0; b < GRAN_BYTES; b++) begin : g_rdMask
      assign rdBitMask[8*b +: 8] = {8{sizeMask[b]}};
    end
  endgenerate

  // merge and extract through a two-granule window
  always_comb begin
    placed = {{GRAN_BITS{1'b0}}, reqWData} << bitShift;
    newWin = (win & ~wrBitMask) | (placed & wrBitMask);
    rdWin  = GRAN_BITS'(win >> bitShift);
  end

  // data rows: no reset
  always_ff @(posedge clk) begin
    if (ctl.wrLo) memQ[idxLo] <= newWin[GRAN_BITS-1:0];
    if (ctl.wrHi) memQ[idxHi] <= newWin[WIN_BITS-1:GRAN_BITS];
  end

  // tag bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagQ <= '0;
    end else begin
      if (ctl.wrLo) tagQ[idxLo] <= ctl.capWr & ctl.tagVal;
      if (ctl.wrHi) tagQ[idxHi] <= 1'b0;
    end
  end

  // registered response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
      rspTag   <= 1'b0;
    end else begin
      rspValid <= ctl.fire;
      rspErr   <= ctl.err;
      rspTag   <= ctl.rdCap & tagQ[idxLo];
      if (ctl.rdCap)       rspData <= memQ[idxLo];
      else if (ctl.rdData) rspData <= rdWin & rdBitMask;
      else                 rspData <= '0;
    end
  end

endmodule

// File: rtl/tagged_granule_ctrl.sv
module tagged_granule_ctrl
  import tgc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int GRANULES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [1:0]         reqKind,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [4:0]         reqSize,
  input  logic [127:0]       reqWData,
  input  logic               reqWTag,
  output logic               rspValid,
  output logic               rspErr,
  output logic [127:0]       rspData,
  output logic               rspTag
);

  localparam int IDX_W = $clog2(GRANULES);

  dpCtl_t            ctl;
  logic [OFF_W-1:0]  reqOff;
  logic [IDX_W-1:0]  idxLo;
  logic              unusedHighAddr;

  assign reqOff         = reqAddr[OFF_W-1:0];
  assign idxLo          = reqAddr[OFF_W +: IDX_W];
  assign unusedHighAddr = ^reqAddr[ADDR_W-1:OFF_W+IDX_W];

  tgc_ctrl ctrl_i (
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqOff   (reqOff),
    .reqSize  (reqSize),
    .reqWTag  (reqWTag),
    .reqReady (reqReady),
    .ctl      (ctl)
  );

  tgc_datapath #(.GRANULES(GRANULES)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .idxLo    (idxLo),
    .reqOff   (reqOff),
    .reqSize  (reqSize),
    .reqWData (reqWData),
    .rspValid (rspValid),
    .rspErr   (rspErr),
    .rspData  (rspData),
    .rspTag   (rspTag)
  );

endmodule

// File: rtl/tgc_chk.sv
module tgc_chk (
  input logic         clk,
  input logic         rstN,
  input logic         reqValid,
  input logic [1:0]   reqKind,
  input logic [3:0]   reqOff,
  input logic [4:0]   reqSize,
  input logic         rspValid,
  input logic         rspErr,
  input logic [127:0] rspData,
  input logic         rspTag
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R7
  data_load_untagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd0) |=> !rspTag);

  // R5
  misaligned_cap_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind[1] && reqOff != 4'd0) |=> rspErr);

  // R5
  err_rsp_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspData == '0 && !rspTag));

  // R8
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqKind[1] && (reqSize == 5'd0 || reqSize > 5'd16)) |=> rspErr);

  // R3
  good_cap_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind[1] && reqOff == 4'd0) |=> !rspErr);

endmodule

bind tagged_granule_ctrl tgc_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqKind  (reqKind),
  .reqOff   (reqAddr[3:0]),
  .reqSize  (reqSize),
  .rspValid (rspValid),
  .rspErr   (rspErr),
  .rspData  (rspData),
  .rspTag   (rspTag)
);

// File: tb/tagged_granule_ctrl_tb_top.sv
module tagged_granule_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;

  localparam logic [127:0] PAT_A   = 128'h00112233_44556677_8899aabb_ccddeeff;
  localparam logic [127:0] PAT_A4  = 128'h00112233_44556677_8899aa5a_ccddeeff;
  localparam logic [127:0] PAT_A14 = 128'h33442233_44556677_8899aabb_ccddeeff;
  localparam logic [127:0] PAT_B   = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
  localparam logic [127:0] PAT_B1  = 128'h0f0e0d0c_0b0a0908_07060504_03021122;
  localparam logic [127:0] PAT_C   = 128'h00000000_00000000_00000000_cafef00d;
  localparam logic [127:0] PAT_D   = 128'h99999999_99999999_12345678_9abcdef0;

  typedef struct packed {
    logic [7:0]        reqId;
    logic [1:0]        kind;
    logic [ADDR_W-1:0] addr;
    logic [4:0]        size;
    logic [127:0]      wdata;
    logic              wtag;
    logic              expErr;
    logic [127:0]      expData;
    logic              expTag;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VECS [NVEC] = '{
    '{8'd3,  2'd3, 12'h000, 5'd16, PAT_A, 1'b1, 1'b0, 128'h0,       1'b0}, // R3 cap write tag 1
    '{8'd3,  2'd2, 12'h000, 5'd16, 128'h0, 1'b0, 1'b0, PAT_A,       1'b1}, // R3 cap read
    '{8'd7,  2'd0, 12'h000, 5'd4,  128'h0, 1'b0, 1'b0, 128'hccddeeff, 1'b0}, // R7 tag hidden
    '{8'd3,  2'd2, 12'h000, 5'd16, 128'h0, 1'b0, 1'b0, PAT_A,       1'b1}, // R3 read keeps tag
    '{8'd3,  2'd3, 12'h010, 5'd16, PAT_B, 1'b1, 1'b0, 128'h0,       1'b0}, // R3
    '{8'd4,  2'd3, 12'h020, 5'd16, PAT_C, 1'b0, 1'b0, 128'h0,       1'b0}, // R4
    '{8'd4,  2'd2, 12'h020, 5'd16, 128'h0, 1'b0, 1'b0, PAT_C,       1'b0}, // R4 tag cleared
    '{8'd10, 2'd1, 12'h004, 5'd1,  128'h5a, 1'b0, 1'b0, 128'h0,      1'b0}, // R10 one byte
    '{8'd6,  2'd2, 12'h000, 5'd16, 128'h0, 1'b0, 1'b0, PAT_A4,      1'b0}, // R6 R10
    '{8'd6,  2'd2, 12'h010, 5'd16, 128'h0, 1'b0, 1'b0, PAT_B,       1'b1}, // R6 neighbour kept
    '{8'd5,  2'd3, 12'h008, 5'd16, PAT_C, 1'b1, 1'b1, 128'h0,       1'b0}, // R5 misaligned write
    '{8'd5,  2'd2, 12'h000, 5'd16, 128'h0, 1'b0, 1'b0, PAT_A4,      1'b0}, // R5 nothing changed
    '{8'd3,  2'd3, 12'h000, 5'd16, PAT_A, 1'b1, 1'b0, 128'h0,       1'b0}, // R3
    '{8'd6,  2'd1, 12'h00e, 5'd4,  128'h11223344, 1'b0, 1'b0, 128'h0, 1'b0}, // R6 straddle
    '{8'd6,  2'd2, 12'h000, 5'd16, 128'h0, 1'b0, 1'b0, PAT_A14,     1'b0}, // R6 R10 low granule
    '{8'd6,  2'd2, 12'h010, 5'd16, 128'h0, 1'b0, 1'b0, PAT_B1,      1'b0}, // R6 R10 high granule
    '{8'd7,  2'd0, 12'h00e, 5'd4,  128'h0, 1'b0, 1'b0, 128'h11223344, 1'b0}, // R7 straddle read
    '{8'd8,  2'd0, 12'h000, 5'd0,  128'h0, 1'b0, 1'b1, 128'h0,      1'b0}, // R8 size zero
    '{8'd8,  2'd1, 12'h000, 5'd17, 128'hff, 1'b0, 1'b1, 128'h0,     1'b0}, // R8 size 17
    '{8'd5,  2'd2, 12'h004, 5'd16, 128'h0, 1'b0, 1'b1, 128'h0,      1'b0}, // R5 misaligned read
    '{8'd8,  2'd0, 12'h000, 5'd16, 128'h0, 1'b0, 1'b0, PAT_A14,     1'b0}, // R8 R7 full read, R8 write had no effect
    '{8'd9,  2'd2, 12'h110, 5'd16, 128'h0, 1'b0, 1'b0, PAT_B1,      1'b0}  // R9 high bits ignored
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [1:0]        reqKind = 2'd0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [4:0]        reqSize = 5'd0;
  logic [127:0]      reqWData = '0;
  logic              reqWTag = 1'b0;
  logic              rspValid;
  logic              rspErr;
  logic [127:0]      rspData;
  logic              rspTag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_granule_ctrl #(.ADDR_W(ADDR_W), .GRANULES(16)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWData(reqWData), .reqWTag(reqWTag), .rspValid(rspValid),
    .rspErr(rspErr), .rspData(rspData), .rspTag(rspTag)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at falling edge, sample just after the accepting rising edge
  task automatic issue(input logic [1:0] k, input logic [ADDR_W-1:0] a, input logic [4:0] s,
                       input logic [127:0] wd, input logic wt);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqSize = s; reqWData = wd; reqWTag = wt;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 rspValid in reset", 128'(rspValid), 128'd0);
    check("R2 reqReady", 128'(reqReady), 128'd1);
    @(negedge clk) rstN = 1'b1;
    idle();
    check("R1 no response after reset", 128'(rspValid), 128'd0);
    issue(2'd2, 12'h050, 5'd16, '0, 1'b0);
    check("R1 tag clear after reset", 128'(rspTag), 128'd0);
    check("R2 rspValid after request", 128'(rspValid), 128'd1);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      string tg;
      issue(VECS[i].kind, VECS[i].addr, VECS[i].size, VECS[i].wdata, VECS[i].wtag);
      tg = $sformatf("R%0d vec%0d", VECS[i].reqId, i);
      check({tg, " valid"}, 128'(rspValid), 128'd1);
      check({tg, " err"},   128'(rspErr),   128'(VECS[i].expErr));
      check({tg, " data"},  rspData,        VECS[i].expData);
      check({tg, " tag"},   128'(rspTag),   128'(VECS[i].expTag));
    end

    // R2 idle cycle gives no response
    idle();
    check("R2 idle no rspValid", 128'(rspValid), 128'd0);

    // R9 wrap from last granule into granule 0
    issue(2'd3, 12'h000, 5'd16, PAT_A, 1'b1);
    issue(2'd3, 12'h0f0, 5'd16, PAT_B, 1'b1);
    issue(2'd1, 12'h0f8, 5'd16, PAT_D, 1'b0);
    issue(2'd2, 12'h0f0, 5'd16, '0, 1'b0);
    check("R9 last granule data", rspData, 128'h12345678_9abcdef0_07060504_03020100);
    check("R9 R6 last granule tag", 128'(rspTag), 128'd0);
    issue(2'd2, 12'h000, 5'd16, '0, 1'b0);
    check("R9 wrapped granule data", rspData, 128'h00112233_44556677_99999999_99999999);
    check("R9 R6 wrapped granule tag", 128'(rspTag), 128'd0);

    // R1 reset clears a set tag
    issue(2'd3, 12'h030, 5'd16, PAT_C, 1'b1);
    issue(2'd2, 12'h030, 5'd16, '0, 1'b0);
    check("R3 tag set before reset", 128'(rspTag), 128'd1);
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    issue(2'd2, 12'h030, 5'd16, '0, 1'b0);
    check("R1 tag cleared by reset", 128'(rspTag), 128'd0);
    idle();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule